// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Per-Port Aspect Ratio

A true dual-port synchronous memory of 16 Kbit data plus 2 Kbit parity, built from `ROWS` rows of 36 bits (32 data bits and 4 parity bits per row). Each port has its own clock, enable, write enable, set/reset, address, data and parity inputs, and a registered data and parity output. Each port's shape is fixed at elaboration by its width parameter, and both ports see the same stored bits.

A width parameter of 1, 2, 4, 9, 18 or 36 gives the port's data width (1, 2, 4, 8, 16, 32), its parity width (0, 0, 0, 1, 2, 4) and its address width. Per port, parameters select the clock edge, what the output register shows on a write edge, and the constant that set/reset loads into the output register.

Top module: `dual_port_ram`

## Requirements
- R1: With default `ROWS`=512, a port of width 1/2/4/9/18/36 has an address of 14/13/12/11/10/9 bits. Its highest address reaches the top data bits and top parity lane of the memory.
- R2: With enable high, write enable low and set/reset low, the active edge loads the addressed data word and its parity bits into the output registers.
- R3: Data and parity are addressed per port. Address `a` on a port with data width DW holds data bits `[a*DW +: DW]` of the shared data space. It holds parity bits `[a*PW +: PW]` of the shared parity space. So both ports agree on the bits whatever their widths.
- R4: In write-first mode (`WM_WRITE_FIRST`), a write edge stores the input word and also loads the input data and parity into the output registers.
- R5: In read-first mode (`WM_READ_FIRST`), a write edge stores the input word and loads the output registers with what the cell held before the write.
- R6: In no-change mode (`WM_NO_CHANGE`), a write edge stores the input word and leaves the output registers unchanged.
- R7: With enable low, the port neither writes memory nor changes its output registers, whatever its write enable, set/reset, address and data inputs carry.
- R8: Set/reset high with enable high loads the port's output registers with its `SR_DATA`/`SR_PAR` constants on the active edge. The set/reset itself does not alter memory contents.
- R9: A port with its `NEG_EDGE` parameter set acts only on falling edges of its clock; otherwise only on rising edges.
- R10: While `rst_ni` is low, both output registers hold their set/reset constants at once, without waiting for a clock edge, and all memory contents read as zero afterwards.
- R11: Ports of width 1, 2 and 4 have no parity lane. Their 1-bit parity input is ignored and their 1-bit parity output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_a_i | input | 1 | Port A clock |
| en_a_i | input | 1 | Port A enable |
| we_a_i | input | 1 | Port A write enable |
| sr_a_i | input | 1 | Port A synchronous output set/reset |
| addr_a_i | input | A_AW | Port A address |
| din_a_i | input | A_DW | Port A write data |
| pin_a_i | input | A_PWP | Port A write parity |
| dout_a_o | output | A_DW | Port A registered read data |
| pout_a_o | output | A_PWP | Port A registered read parity |
| clk_b_i | input | 1 | Port B clock |
| en_b_i | input | 1 | Port B enable |
| we_b_i | input | 1 | Port B write enable |
| sr_b_i | input | 1 | Port B synchronous output set/reset |
| addr_b_i | input | B_AW | Port B address |
| din_b_i | input | B_DW | Port B write data |
| pin_b_i | input | B_PWP | Port B write parity |
| dout_b_o | output | B_DW | Port B registered read data |
| pout_b_o | output | B_PWP | Port B registered read parity |

## Verification
A wrong lane shift or row index in one port shows up on the other port's output one active edge after it reads the affected address. Writing through one shape and reading back through another catches it on the first cross read. A wrong stored bit in either storage bank corrupts the combined word that both ports see. It appears on the next read of that row from either side, so the bench interleaves wide and narrow accesses to the same rows. A wrong output-register mode or edge choice changes the value sampled half a cycle or one cycle after the write edge, before any later access can mask it.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int ROW_DATA = 32;
  localparam int ROW_PAR  = 4;
  localparam int ROW_BITS = ROW_DATA + ROW_PAR;

  typedef enum logic [1:0] {
    WM_WRITE_FIRST = 2'd0,
    WM_READ_FIRST  = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wmode_e;

  function automatic int data_w(int w);
    return (w >= 9) ? (w / 9) * 8 : w;
  endfunction

  function automatic int par_w(int w);
    return (w >= 9) ? w / 9 : 0;
  endfunction

  // parity pin width, never zero
  function automatic int par_pin_w(int w);
    return (w >= 9) ? w / 9 : 1;
  endfunction

  function automatic int addr_w(int rows, int w);
    return $clog2(rows) + $clog2(ROW_DATA / data_w(w));
  endfunction
endpackage

// File: rtl/dpram_lane_map.sv
module dpram_lane_map
  import dpram_pkg::*;
#(
  parameter int ROWS = 512,
  parameter int DW   = 32,
  parameter int PW   = 4,
  localparam int PWP   = (PW > 0) ? PW : 1,
  localparam int LANES = ROW_DATA / DW,
  localparam int LS    = $clog2(LANES),
  localparam int RW    = $clog2(ROWS),
  localparam int AW    = RW + LS
) (
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       din_i,
  input  logic [PWP-1:0]      pin_i,
  input  logic [ROW_BITS-1:0] row_word_i,
  output logic [RW-1:0]       row_o,
  output logic [ROW_BITS-1:0] wmask_o,
  output logic [ROW_BITS-1:0] wplace_o,
  output logic [DW-1:0]       rdata_o,
  output logic [PWP-1:0]      rpar_o
);
  localparam logic [ROW_DATA-1:0] DMASK = ROW_DATA'((64'd1 << DW) - 64'd1);

  logic [31:0] lane_idx;

  generate
    if (LS > 0) begin : g_lanes
      assign row_o    = addr_i[AW-1:LS];
      assign lane_idx = 32'(addr_i[LS-1:0]);
    end else begin : g_full
      assign row_o    = addr_i;
      assign lane_idx = '0;
    end
  endgenerate

  assign wmask_o[ROW_DATA-1:0]  = DMASK << (lane_idx * DW);
  assign wplace_o[ROW_DATA-1:0] = ROW_DATA'(din_i) << (lane_idx * DW);
  assign rdata_o = DW'(row_word_i[ROW_DATA-1:0] >> (lane_idx * DW));

  generate
    if (PW > 0) begin : g_par
      localparam logic [ROW_PAR-1:0] PMASK = ROW_PAR'((8'd1 << PW) - 8'd1);
      assign wmask_o[ROW_BITS-1:ROW_DATA]  = PMASK << (lane_idx * PW);
      assign wplace_o[ROW_BITS-1:ROW_DATA] = ROW_PAR'(pin_i) << (lane_idx * PW);
      assign rpar_o = PWP'(row_word_i[ROW_BITS-1:ROW_DATA] >> (lane_idx * PW));
    end else begin : g_nopar
      logic unused_par;
      assign unused_par = ^{pin_i, row_word_i[ROW_BITS-1:ROW_DATA]};
      assign wmask_o[ROW_BITS-1:ROW_DATA]  = '0;
      assign wplace_o[ROW_BITS-1:ROW_DATA] = '0;
      assign rpar_o = '0;
    end
  endgenerate
endmodule

// File: rtl/dpram_bank.sv
module dpram_bank
  import dpram_pkg::*;
#(
  parameter int ROWS     = 512,
  parameter bit NEG_EDGE = 1'b0,
  localparam int RW = $clog2(ROWS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [RW-1:0]       row_i,
  input  logic [ROW_BITS-1:0] wmask_i,
  input  logic [ROW_BITS-1:0] wdata_i,
  input  logic [RW-1:0]       peer_row_i,
  output logic [ROW_BITS-1:0] own_q_o,
  output logic [ROW_BITS-1:0] peer_q_o
);
  logic [ROW_BITS-1:0] mem_q [ROWS];

  assign own_q_o  = mem_q[row_i];
  assign peer_q_o = mem_q[peer_row_i];

  generate
    if (NEG_EDGE) begin : g_neg
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < ROWS; i++) mem_q[i] <= '0;
        end else if (we_i) begin
          mem_q[row_i] <= (mem_q[row_i] & ~wmask_i) | (wdata_i & wmask_i);
        end
      end
    end else begin : g_pos
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < ROWS; i++) mem_q[i] <= '0;
        end else if (we_i) begin
          mem_q[row_i] <= (mem_q[row_i] & ~wmask_i) | (wdata_i & wmask_i);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/dpram_port.sv
module dpram_port
  import dpram_pkg::*;
#(
  parameter int          ROWS     = 512,
  parameter int          WIDTH    = 36,
  parameter wmode_e      MODE     = WM_WRITE_FIRST,
  parameter bit          NEG_EDGE = 1'b0,
  parameter logic [31:0] SR_DATA  = '0,
  parameter logic [3:0]  SR_PAR   = '0,
  localparam int DW  = data_w(WIDTH),
  localparam int PW  = par_w(WIDTH),
  localparam int PWP = par_pin_w(WIDTH),
  localparam int RW  = $clog2(ROWS),
  localparam int AW  = addr_w(ROWS, WIDTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                we_i,
  input  logic                sr_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       din_i,
  input  logic [PWP-1:0]      pin_i,
  output logic [DW-1:0]       dout_o,
  output logic [PWP-1:0]      pout_o,
  input  logic [ROW_BITS-1:0] peer_word_i,
  input  logic [RW-1:0]       peer_row_i,
  output logic [RW-1:0]       row_o,
  output logic [ROW_BITS-1:0] bank_at_peer_o
);
  localparam logic [DW-1:0]  SRD = SR_DATA[DW-1:0];
  localparam logic [PWP-1:0] SRP = (PW > 0) ? SR_PAR[PWP-1:0] : '0;

  logic [ROW_BITS-1:0] own_q, read_word, wmask, wplace, wenc;
  logic [DW-1:0]       rdata, next_d, dout_q;
  logic [PWP-1:0]      rpar, next_p, pout_q;

  dpram_lane_map #(.ROWS(ROWS), .DW(DW), .PW(PW)) u_map (
    .addr_i    (addr_i),
    .din_i     (din_i),
    .pin_i     (pin_i),
    .row_word_i(read_word),
    .row_o     (row_o),
    .wmask_o   (wmask),
    .wplace_o  (wplace),
    .rdata_o   (rdata),
    .rpar_o    (rpar)
  );

  // stored value is own bank xor peer bank
  assign read_word = own_q ^ peer_word_i;
  assign wenc      = wplace ^ peer_word_i;

  dpram_bank #(.ROWS(ROWS), .NEG_EDGE(NEG_EDGE)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (en_i & we_i),
    .row_i     (row_o),
    .wmask_i   (wmask),
    .wdata_i   (wenc),
    .peer_row_i(peer_row_i),
    .own_q_o   (own_q),
    .peer_q_o  (bank_at_peer_o)
  );

  always_comb begin
    next_d = dout_q;
    next_p = pout_q;
    if (en_i) begin
      if (sr_i) begin
        next_d = SRD;
        next_p = SRP;
      end else if (we_i) begin
        case (MODE)
          WM_WRITE_FIRST: begin
            next_d = din_i;
            next_p = (PW > 0) ? pin_i : '0;
          end
          WM_READ_FIRST: begin
            next_d = rdata;
            next_p = rpar;
          end
          default: ;
        endcase
      end else begin
        next_d = rdata;
        next_p = rpar;
      end
    end
  end

  generate
    if (NEG_EDGE) begin : g_neg
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          dout_q <= SRD;
          pout_q <= SRP;
        end else begin
          dout_q <= next_d;
          pout_q <= next_p;
        end
      end
    end else begin : g_pos
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          dout_q <= SRD;
          pout_q <= SRP;
        end else begin
          dout_q <= next_d;
          pout_q <= next_p;
        end
      end
    end
  endgenerate

  assign dout_o = dout_q;
  assign pout_o = pout_q;

  logic pclk;
  assign pclk = NEG_EDGE ? ~clk_i : clk_i;

  p_hold_idle_r7: assert property (@(posedge pclk) disable iff (!rst_ni)
    !en_i |=> $stable(dout_o) && $stable(pout_o));

  p_sr_load_r8: assert property (@(posedge pclk) disable iff (!rst_ni)
    en_i && sr_i |=> dout_o == SRD && pout_o == SRP);

  p_read_r2: assert property (@(posedge pclk) disable iff (!rst_ni)
    en_i && !sr_i && !we_i |=> dout_o == $past(rdata) && pout_o == $past(rpar));

  generate
    if (MODE == WM_WRITE_FIRST) begin : g_chk_wf
      p_write_first_r4: assert property (@(posedge pclk) disable iff (!rst_ni)
        en_i && we_i && !sr_i |=> dout_o == $past(din_i));
    end else if (MODE == WM_READ_FIRST) begin : g_chk_rf
      p_read_first_r5: assert property (@(posedge pclk) disable iff (!rst_ni)
        en_i && we_i && !sr_i |=> dout_o == $past(rdata) && pout_o == $past(rpar));
    end else begin : g_chk_nc
      p_no_change_r6: assert property (@(posedge pclk) disable iff (!rst_ni)
        en_i && we_i && !sr_i |=> $stable(dout_o) && $stable(pout_o));
    end
  endgenerate
endmodule

// File: rtl/dual_port_ram.sv
module dual_port_ram
  import dpram_pkg::*;
#(
  parameter int          ROWS      = 512,
  parameter int          A_WIDTH   = 36,
  parameter wmode_e      A_MODE    = WM_WRITE_FIRST,
  parameter bit          A_NEG     = 1'b0,
  parameter logic [31:0] A_SR_DATA = '0,
  parameter logic [3:0]  A_SR_PAR  = '0,
  parameter int          B_WIDTH   = 9,
  parameter wmode_e      B_MODE    = WM_READ_FIRST,
  parameter bit          B_NEG     = 1'b0,
  parameter logic [31:0] B_SR_DATA = '0,
  parameter logic [3:0]  B_SR_PAR  = '0,
  localparam int A_DW  = data_w(A_WIDTH),
  localparam int A_PWP = par_pin_w(A_WIDTH),
  localparam int A_AW  = addr_w(ROWS, A_WIDTH),
  localparam int B_DW  = data_w(B_WIDTH),
  localparam int B_PWP = par_pin_w(B_WIDTH),
  localparam int B_AW  = addr_w(ROWS, B_WIDTH)
) (
  input  logic             rst_ni,
  input  logic             clk_a_i,
  input  logic             en_a_i,
  input  logic             we_a_i,
  input  logic             sr_a_i,
  input  logic [A_AW-1:0]  addr_a_i,
  input  logic [A_DW-1:0]  din_a_i,
  input  logic [A_PWP-1:0] pin_a_i,
  output logic [A_DW-1:0]  dout_a_o,
  output logic [A_PWP-1:0] pout_a_o,
  input  logic             clk_b_i,
  input  logic             en_b_i,
  input  logic             we_b_i,
  input  logic             sr_b_i,
  input  logic [B_AW-1:0]  addr_b_i,
  input  logic [B_DW-1:0]  din_b_i,
  input  logic [B_PWP-1:0] pin_b_i,
  output logic [B_DW-1:0]  dout_b_o,
  output logic [B_PWP-1:0] pout_b_o
);
  localparam int RW = $clog2(ROWS);

  logic [RW-1:0]       row_a, row_b;
  logic [ROW_BITS-1:0] a_at_b, b_at_a;

  dpram_port #(
    .ROWS(ROWS), .WIDTH(A_WIDTH), .MODE(A_MODE), .NEG_EDGE(A_NEG),
    .SR_DATA(A_SR_DATA), .SR_PAR(A_SR_PAR)
  ) u_port_a (
    .clk_i(clk_a_i), .rst_ni(rst_ni), .en_i(en_a_i), .we_i(we_a_i), .sr_i(sr_a_i),
    .addr_i(addr_a_i), .din_i(din_a_i), .pin_i(pin_a_i),
    .dout_o(dout_a_o), .pout_o(pout_a_o),
    .peer_word_i(b_at_a), .peer_row_i(row_b), .row_o(row_a), .bank_at_peer_o(a_at_b)
  );

  dpram_port #(
    .ROWS(ROWS), .WIDTH(B_WIDTH), .MODE(B_MODE), .NEG_EDGE(B_NEG),
    .SR_DATA(B_SR_DATA), .SR_PAR(B_SR_PAR)
  ) u_port_b (
    .clk_i(clk_b_i), .rst_ni(rst_ni), .en_i(en_b_i), .we_i(we_b_i), .sr_i(sr_b_i),
    .addr_i(addr_b_i), .din_i(din_b_i), .pin_i(pin_b_i),
    .dout_o(dout_b_o), .pout_o(pout_b_o),
    .peer_word_i(a_at_b), .peer_row_i(row_a), .row_o(row_b), .bank_at_peer_o(b_at_a)
  );
endmodule

// File: tb/sim_dual_port_ram.sv
module sim_dual_port_ram;
  import dpram_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // port index: 0 u0.A, 1 u0.B (falling edge), 2 u1.A, 3 u1.B
  logic        en [4];
  logic        we [4];
  logic        sr [4];
  logic [31:0] addr [4];
  logic [31:0] din [4];
  logic [3:0]  pin [4];

  logic [31:0] d0; logic [3:0] p0;
  logic [7:0]  d1; logic [0:0] p1;
  logic [3:0]  d2; logic [0:0] p2;
  logic [15:0] d3; logic [1:0] p3;

  dual_port_ram #(
    .A_WIDTH(36), .A_MODE(WM_WRITE_FIRST), .A_NEG(1'b0), .A_SR_DATA(32'hDEADBEEF), .A_SR_PAR(4'hA),
    .B_WIDTH(9),  .B_MODE(WM_READ_FIRST),  .B_NEG(1'b1), .B_SR_DATA(32'h5A),       .B_SR_PAR(4'h1)
  ) u0 (
    .rst_ni(rst_ni),
    .clk_a_i(clk), .en_a_i(en[0]), .we_a_i(we[0]), .sr_a_i(sr[0]), .addr_a_i(addr[0][8:0]),
    .din_a_i(din[0]), .pin_a_i(pin[0]), .dout_a_o(d0), .pout_a_o(p0),
    .clk_b_i(clk), .en_b_i(en[1]), .we_b_i(we[1]), .sr_b_i(sr[1]), .addr_b_i(addr[1][10:0]),
    .din_b_i(din[1][7:0]), .pin_b_i(pin[1][0:0]), .dout_b_o(d1), .pout_b_o(p1)
  );

  dual_port_ram #(
    .A_WIDTH(4),  .A_MODE(WM_NO_CHANGE),   .A_NEG(1'b0), .A_SR_DATA(32'h3),    .A_SR_PAR(4'h0),
    .B_WIDTH(18), .B_MODE(WM_WRITE_FIRST), .B_NEG(1'b0), .B_SR_DATA(32'hC0DE), .B_SR_PAR(4'h2)
  ) u1 (
    .rst_ni(rst_ni),
    .clk_a_i(clk), .en_a_i(en[2]), .we_a_i(we[2]), .sr_a_i(sr[2]), .addr_a_i(addr[2][11:0]),
    .din_a_i(din[2][3:0]), .pin_a_i(pin[2][0:0]), .dout_a_o(d2), .pout_a_o(p2),
    .clk_b_i(clk), .en_b_i(en[3]), .we_b_i(we[3]), .sr_b_i(sr[3]), .addr_b_i(addr[3][9:0]),
    .din_b_i(din[3][15:0]), .pin_b_i(pin[3][1:0]), .dout_b_o(d3), .pout_b_o(p3)
  );

  // configuration as the requirements define it
  int          cf_dw [4]  = '{32, 8, 4, 16};
  int          cf_pw [4]  = '{4, 1, 0, 2};
  int          cf_md [4]  = '{0, 1, 2, 0};   // 0 write-first, 1 read-first, 2 no-change
  int          cf_dut [4] = '{0, 0, 1, 1};
  logic [31:0] cf_srd [4] = '{32'hDEADBEEF, 32'h5A, 32'h3, 32'hC0DE};
  logic [3:0]  cf_srp [4] = '{4'hA, 4'h1, 4'h0, 4'h2};

  logic [16383:0] mdl_d [2];
  logic [2047:0]  mdl_p [2];
  logic [31:0]    exp_d [4];
  logic [3:0]     exp_p [4];

  typedef struct {
    logic [31:0] d;
    logic [3:0]  p;
    string       tag;
  } item_t;
  item_t sb_q [4][$];

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  function automatic logic [31:0] act_d(int p);
    case (p)
      0: return d0;
      1: return 32'(d1);
      2: return 32'(d2);
      default: return 32'(d3);
    endcase
  endfunction

  function automatic logic [3:0] act_p(int p);
    case (p)
      0: return p0;
      1: return 4'(p1);
      2: return 4'(p2);
      default: return 4'(p3);
    endcase
  endfunction

  task automatic compare(int p, logic [31:0] ed, logic [3:0] ep, string tag);
    checks++;
    if (act_d(p) !== ed || act_p(p) !== ep) begin
      failures++;
      $display("FAIL %s port%0d: got d=%h p=%h expected d=%h p=%h",
               tag, p, act_d(p), act_p(p), ed, ep);
    end
  endtask

  task automatic monitor_port(int p);
    item_t it;
    if (sb_q[p].size() > 0) begin
      it = sb_q[p].pop_front();
      compare(p, it.d, it.p, it.tag);
    end
  endtask

  initial forever begin
    @(posedge clk); #1;
    monitor_port(0); monitor_port(2); monitor_port(3);
  end

  initial forever begin
    @(negedge clk); #1;
    monitor_port(1);
  end

  task automatic clear_model();
    for (int k = 0; k < 2; k++) begin
      mdl_d[k] = '0;
      mdl_p[k] = '0;
    end
    for (int q = 0; q < 4; q++) begin
      exp_d[q] = cf_srd[q] & ((32'h1 << cf_dw[q]) - 32'h1 | (cf_dw[q] == 32 ? 32'hFFFFFFFF : 32'h0));
      exp_p[q] = (cf_pw[q] > 0) ? (cf_srp[q] & 4'((8'h1 << cf_pw[q]) - 8'h1)) : 4'h0;
    end
  endtask

  // driver: one access on one port per cycle, all other ports idle
  task automatic op(int p, bit e, bit w, bit s, int a, logic [31:0] d, logic [3:0] pp, string tag);
    logic [31:0] old_d, dm;
    logic [3:0]  old_p, pm;
    item_t       it;
    int          m;
    @(posedge clk); #2;
    for (int q = 0; q < 4; q++) begin
      en[q] = 1'b0; we[q] = 1'b0; sr[q] = 1'b0;
    end
    en[p] = e; we[p] = w; sr[p] = s; addr[p] = 32'(a); din[p] = d; pin[p] = pp;
    m = cf_dut[p];
    old_d = '0; old_p = '0; dm = '0; pm = '0;
    for (int i = 0; i < cf_dw[p]; i++) begin
      old_d[i] = mdl_d[m][a * cf_dw[p] + i];
      dm[i] = d[i];
    end
    for (int i = 0; i < cf_pw[p]; i++) begin
      old_p[i] = mdl_p[m][a * cf_pw[p] + i];
      pm[i] = pp[i];
    end
    if (e) begin
      if (s) begin
        exp_d[p] = '0; exp_p[p] = '0;
        for (int i = 0; i < cf_dw[p]; i++) exp_d[p][i] = cf_srd[p][i];
        for (int i = 0; i < cf_pw[p]; i++) exp_p[p][i] = cf_srp[p][i];
      end else if (w) begin
        if (cf_md[p] == 0) begin exp_d[p] = dm; exp_p[p] = pm; end
        else if (cf_md[p] == 1) begin exp_d[p] = old_d; exp_p[p] = old_p; end
      end else begin
        exp_d[p] = old_d; exp_p[p] = old_p;
      end
      if (w) begin
        for (int i = 0; i < cf_dw[p]; i++) mdl_d[m][a * cf_dw[p] + i] = dm[i];
        for (int i = 0; i < cf_pw[p]; i++) mdl_p[m][a * cf_pw[p] + i] = pm[i];
      end
    end
    it.d = exp_d[p]; it.p = exp_p[p]; it.tag = tag;
    sb_q[p].push_back(it);
  endtask

  task automatic check_all_direct(string tag);
    for (int q = 0; q < 4; q++) compare(q, exp_d[q], exp_p[q], tag);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int q = 0; q < 4; q++) begin
      en[q] = 0; we[q] = 0; sr[q] = 0; addr[q] = '0; din[q] = '0; pin[q] = '0;
    end
    clear_model();
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #1 check_all_direct("R10 reset value");
    #1 rst_ni = 1'b1;

    op(0, 1, 0, 0, 5, 0, 0, "R10 cleared content");
    op(0, 1, 1, 0, 0, 32'h44332211, 4'b0110, "R4 write-first wide");
    op(0, 1, 1, 0, 3, 32'h12345678, 4'b1001, "R4 write-first wide");
    op(0, 1, 0, 0, 0, 0, 0, "R2 read wide");
    op(1, 1, 0, 0, 1, 0, 0, "R3 R9 narrow lane read on falling edge");
    op(1, 1, 0, 0, 13, 0, 0, "R3 narrow lane read");
    op(1, 1, 1, 0, 2, 32'hAB, 4'h0, "R5 read-first old value");
    op(0, 1, 0, 0, 0, 0, 0, "R3 wide sees narrow write");
    op(1, 0, 1, 0, 2, 32'hFF, 4'h1, "R7 disabled write holds output");
    op(1, 1, 0, 0, 2, 0, 0, "R7 disabled write left memory");
    op(1, 1, 1, 0, 2047, 32'hC3, 4'h1, "R1 top address write");
    op(0, 1, 0, 0, 511, 0, 0, "R1 top address via wide port");
    op(0, 1, 0, 1, 0, 0, 0, "R8 set/reset value");
    op(0, 0, 0, 1, 0, 0, 0, "R7 set/reset without enable");
    op(0, 1, 0, 0, 0, 0, 0, "R8 memory unchanged by set/reset");
    op(1, 1, 0, 1, 0, 0, 0, "R8 R9 set/reset narrow port");

    op(2, 1, 1, 0, 0, 32'h9, 4'h1, "R6 no-change write");
    op(2, 1, 1, 0, 1, 32'hA, 4'h1, "R6 no-change write");
    op(2, 1, 1, 0, 2, 32'hB, 4'h1, "R6 no-change write");
    op(2, 1, 1, 0, 3, 32'hC, 4'h1, "R6 no-change write");
    op(2, 1, 0, 0, 2, 0, 0, "R11 nibble read, parity zero");
    op(3, 1, 0, 0, 0, 0, 0, "R3 halfword gathers nibbles");
    op(3, 1, 1, 0, 1, 32'h5E7F, 4'h3, "R4 write-first halfword");
    op(2, 1, 0, 0, 4, 0, 0, "R3 nibble of halfword");
    op(2, 1, 0, 0, 7, 0, 0, "R3 nibble of halfword");
    op(3, 1, 0, 0, 1, 0, 0, "R2 halfword read with parity");
    op(2, 1, 1, 0, 8, 32'h6, 4'h1, "R6 no-change holds read value");
    op(2, 1, 0, 0, 8, 0, 0, "R11 parity input ignored");
    op(3, 1, 0, 1, 0, 0, 0, "R8 set/reset halfword");
    op(3, 0, 0, 0, 0, 0, 0, "R7 idle hold");

    repeat (2) @(posedge clk);
    #3 rst_ni = 1'b0;
    clear_model();
    #1 check_all_direct("R10 asynchronous reset");
    @(posedge clk); #2 rst_ni = 1'b1;
    op(0, 1, 0, 0, 0, 0, 0, "R10 content cleared");
    op(3, 1, 0, 0, 1, 0, 0, "R10 content cleared");
    op(3, 0, 0, 0, 0, 0, 0, "R7 idle hold");
    repeat (3) @(posedge clk);

    for (int q = 0; q < 4; q++) begin
      checks++;
      if (sb_q[q].size() != 0) begin
        failures++;
        $display("FAIL scoreboard port%0d: got %0d pending expected 0", q, sb_q[q].size());
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule